// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator for a Real-Time Clock

This block keeps a seconds, minutes and hours count for a real-time clock. A one-cycle tick strobe, normally high once per second, moves the count forward. On each tick the block checks the new count against the period chosen in a 2-bit mode field: every second, every minute, every hour or every day. When the period boundary is reached, the block sets a sticky status bit for that mode. If pulses are enabled, it also sends a single-cycle pulse on its interrupt output.

A separate alarm status bit is set by a strobe from outside the block. This bit drives a level-sensitive alarm output until software clears it. Software reaches the block through a small register bus. Writes take effect at the clock edge and reads are combinational on the address. Through this bus software picks the period, turns the pulse on or off, reads the running time and clears status bits by writing ones to them. There is no data stream, so every pin is a plain control or status signal without a handshake.

Top module: `rtc_tick_irq`

## Requirements
- R1: After reset, all three time fields read 0, the control register reads 0 (period mode 0, pulse disabled), the status register reads 0, and both `irq_pulse` and `alarm_level` are low.
- R2: Each cycle with `tick_1hz` high advances seconds. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0. Cycles without a tick leave all fields unchanged.
- R3: In period mode 0, every tick sets status bit 2 and qualifies for a pulse.
- R4: In period mode 1, a tick sets status bit 3 and qualifies for a pulse only when the updated seconds value is 0.
- R5: In period mode 2, a tick sets status bit 4 and qualifies for a pulse only when the updated seconds and minutes are both 0.
- R6: In period mode 3, a tick sets status bit 5 and qualifies for a pulse only when the updated seconds, minutes and hours are all 0.
- R7: A qualifying tick drives `irq_pulse` high for exactly the one cycle after the tick cycle, but only if the enable bit (control bit 2) was set during the tick cycle. With the enable bit clear, no pulse is sent, and the time count and status bits still update.
- R8: Writing address 1 clears every status bit written as 1 and leaves the bits written as 0 unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: `alarm_hit` sets status bit 6. `alarm_level` stays equal to that bit as a held level until software clears it.
- R10: The register map is as follows. Address 0 is control: bits 1:0 hold the period mode and bit 2 holds the enable. Address 1 is status, where bits 0, 1 and 7 read 0. Addresses 2, 3 and 4 read seconds, minutes and hours. All other addresses read 0. A control write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | Time advance strobe, one cycle per second |
| alarm_hit | input | 1 | Sets the alarm status bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | Periodic interrupt, one cycle wide |
| alarm_level | output | 1 | Alarm output, held high while the alarm status bit is set |

## Verification
The assertions allow the tick, alarm strobe and bus write to be high in any cycle and in any combination, including a tick in every cycle. The properties are written to hold under back-to-back ticks, where pulses can merge into a longer high stretch. They assume that inputs change only between clock edges. The stimulus meets this by driving every input on the falling edge. It runs long stretches of ticks in every cycle to reach the minute, hour and day boundaries, and it spaces out other ticks to show the single-cycle pulse shape.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  typedef enum logic [1:0] {
    PER_SEC  = 2'd0,
    PER_MIN  = 2'd1,
    PER_HOUR = 2'd2,
    PER_DAY  = 2'd3
  } period_e;

  localparam int NUM_FIELDS = 3;
  localparam int NUM_MODES  = 4;
  localparam int ST_W       = NUM_MODES + 1;  // mode bits plus alarm
  localparam int ST_LSB     = 2;              // status bit of mode 0

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_SEC   = 3'd2;
  localparam logic [2:0] A_MIN   = 3'd3;
  localparam logic [2:0] A_HOUR  = 3'd4;

  function automatic int field_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return $clog2(m);
  endfunction

endpackage

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
  parameter int LIMIT = 60,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign wrap = inc && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc) begin
      count <= wrap ? '0 : count + W'(1);
    end
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_tick_pkg::*;
#(
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24,
  parameter int TW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [TW-1:0] field_cnt [NUM_FIELDS],
  output logic [NUM_FIELDS-1:0] field_wrap
);

  function automatic int limit_of(input int idx);
    case (idx)
      0:       return SEC_LIMIT;
      1:       return MIN_LIMIT;
      default: return HOUR_LIMIT;
    endcase
  endfunction

  logic [NUM_FIELDS-1:0] field_inc;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    if (g == 0) begin : g_first
      assign field_inc[g] = tick;
    end else begin : g_carry
      assign field_inc[g] = field_wrap[g-1];
    end

    rtc_wrap_counter #(
      .LIMIT (limit_of(g)),
      .W     (TW)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (field_inc[g]),
      .count (field_cnt[g]),
      .wrap  (field_wrap[g])
    );
  end

endmodule

// File: rtl/rtc_period_sel.sv
module rtc_period_sel
  import rtc_tick_pkg::*;
(
  input  logic                  tick,
  input  logic [NUM_FIELDS-1:0] field_wrap,
  input  period_e               mode,
  output logic [NUM_MODES-1:0]  mode_set,
  output logic                  hit
);

  // A wrap of field k means every field up to k is zero after the update.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    if (m == 0) begin : g_every
      assign mode_set[m] = (mode == period_e'(m)) && tick;
    end else begin : g_bound
      assign mode_set[m] = (mode == period_e'(m)) && field_wrap[m-1];
    end
  end

  assign hit = |mode_set;

endmodule

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int TW     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_MODES-1:0] mode_set,
  input  logic                 period_hit,
  input  logic                 alarm_hit,
  input  logic [TW-1:0]        field_cnt [NUM_FIELDS],
  output period_e              mode_q,
  output logic                 pulse_en_q,
  output logic [ST_W-1:0]      st_q,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_q
);

  localparam int ST_MSB = ST_LSB + ST_W - 1;

  logic            ctrl_wr;
  logic            stat_wr;
  logic [ST_W-1:0] st_clr;
  logic [ST_W-1:0] st_set;
  logic [ST_W-1:0] st_d;
  logic            wdata_unused;

  assign wdata_unused = ^{bus_wdata[DATA_W-1:ST_MSB+1]};

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign st_clr  = stat_wr ? bus_wdata[ST_MSB:ST_LSB] : '0;
  assign st_set  = {alarm_hit, mode_set};
  assign st_d    = (st_q & ~st_clr) | st_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PER_SEC;
      pulse_en_q <= 1'b0;
      st_q       <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q     <= period_e'(bus_wdata[1:0]);
        pulse_en_q <= bus_wdata[2];
      end
      st_q  <= st_d;
      irq_q <= period_hit && pulse_en_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): bus_rdata = DATA_W'({pulse_en_q, mode_q});
      ADDR_W'(A_STAT): bus_rdata = DATA_W'({st_q, {ST_LSB{1'b0}}});
      ADDR_W'(A_SEC):  bus_rdata = DATA_W'(field_cnt[0]);
      ADDR_W'(A_MIN):  bus_rdata = DATA_W'(field_cnt[1]);
      ADDR_W'(A_HOUR): bus_rdata = DATA_W'(field_cnt[2]);
      default:         bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
  import rtc_tick_pkg::*;
#(
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              alarm_hit,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              alarm_level
);

  localparam int TW = field_width(SEC_LIMIT, MIN_LIMIT, HOUR_LIMIT);

  logic [TW-1:0]         field_cnt [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] field_wrap;
  logic [NUM_MODES-1:0]  mode_set;
  logic                  period_hit;
  period_e               mode_q;
  logic                  pulse_en_q;
  logic [ST_W-1:0]       st_q;

  rtc_time_chain #(
    .SEC_LIMIT  (SEC_LIMIT),
    .MIN_LIMIT  (MIN_LIMIT),
    .HOUR_LIMIT (HOUR_LIMIT),
    .TW         (TW)
  ) u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_1hz),
    .field_cnt  (field_cnt),
    .field_wrap (field_wrap)
  );

  rtc_period_sel u_sel (
    .tick       (tick_1hz),
    .field_wrap (field_wrap),
    .mode       (mode_q),
    .mode_set   (mode_set),
    .hit        (period_hit)
  );

  rtc_tick_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .TW     (TW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .mode_set   (mode_set),
    .period_hit (period_hit),
    .alarm_hit  (alarm_hit),
    .field_cnt  (field_cnt),
    .mode_q     (mode_q),
    .pulse_en_q (pulse_en_q),
    .st_q       (st_q),
    .bus_rdata  (bus_rdata),
    .irq_q      (irq_pulse)
  );

  assign alarm_level = st_q[ST_W-1];

endmodule

// File: rtl/rtc_tick_irq_checker.sv
module rtc_tick_irq_checker #(
  parameter int TW         = 6,
  parameter int SEC_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          alarm_hit,
  input logic          irq_pulse,
  input logic          alarm_level,
  input logic [TW-1:0] sec_cnt,
  input logic [TW-1:0] hour_cnt,
  input logic [1:0]    mode,
  input logic          pulse_en,
  input logic [4:0]    st
);

  assert_pulse_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick && pulse_en));

  assert_every_tick_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pulse_en && mode == 2'd0) |=> irq_pulse);

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sec_cnt));

  assert_sec_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_cnt < TW'(SEC_LIMIT));

  assert_hour_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hour_cnt < TW'(HOUR_LIMIT));

  assert_alarm_follows_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> alarm_level);

  assert_alarm_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_level) |-> $past(alarm_hit));

  assert_minute_bit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[1]) |-> $past(tick && mode == 2'd1));

endmodule

bind rtc_tick_irq rtc_tick_irq_checker #(
  .TW         (TW),
  .SEC_LIMIT  (SEC_LIMIT),
  .HOUR_LIMIT (HOUR_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick_1hz),
  .alarm_hit   (alarm_hit),
  .irq_pulse   (irq_pulse),
  .alarm_level (alarm_level),
  .sec_cnt     (field_cnt[0]),
  .hour_cnt    (field_cnt[2]),
  .mode        (mode_q),
  .pulse_en    (pulse_en_q),
  .st          (st_q)
);

// File: tb/rtc_tick_irq_test.sv
module rtc_tick_irq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       alarm_hit = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pulse;
  logic       alarm_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // reference state
  int m_sec = 0, m_min = 0, m_hr = 0;
  int m_mode = 0, m_en = 0, m_stat = 0, m_irq = 0;

  always #4 clk = ~clk;

  rtc_tick_irq uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1hz    (tick_1hz),
    .alarm_hit   (alarm_hit),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_pulse   (irq_pulse),
    .alarm_level (alarm_level)
  );

  function automatic int model_read(input int ad);
    case (ad)
      0: return (m_en << 2) | m_mode;
      1: return m_stat;
      2: return m_sec;
      3: return m_min;
      4: return m_hr;
      default: return 0;
    endcase
  endfunction

  task automatic check(input int actual, input int expected, input string req, input string what);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, actual, expected, $time);
    end
  endtask

  task automatic model_edge(input bit t, input bit a, input bit w, input int ad, input int wd);
    bit hit;
    hit = 1'b0;
    if (t) begin
      m_sec++;
      if (m_sec == 60) begin
        m_sec = 0;
        m_min++;
        if (m_min == 60) begin
          m_min = 0;
          m_hr++;
          if (m_hr == 24) m_hr = 0;
        end
      end
      case (m_mode)
        0: hit = 1'b1;
        1: hit = (m_sec == 0);
        2: hit = (m_sec == 0) && (m_min == 0);
        default: hit = (m_sec == 0) && (m_min == 0) && (m_hr == 0);
      endcase
    end
    if (w && ad == 1) m_stat = m_stat & ~(wd & 8'h7C);
    if (hit) m_stat = m_stat | (1 << (2 + m_mode));
    if (a) m_stat = m_stat | 8'h40;
    m_irq = (hit && m_en) ? 1 : 0;
    if (w && ad == 0) begin
      m_mode = wd & 3;
      m_en   = (wd >> 2) & 1;
    end
  endtask

  // called at a falling edge; drives, lets one rising edge pass, compares
  task automatic step(input bit t, input bit a, input bit w, input int ad, input int wd, input string req);
    tick_1hz  = t;
    alarm_hit = a;
    bus_wr    = w;
    bus_addr  = 3'(ad);
    bus_wdata = 8'(wd);
    @(posedge clk);
    model_edge(t, a, w, ad, wd);
    @(negedge clk);
    check(int'(irq_pulse), m_irq, req, "irq_pulse");
    check(int'(alarm_level), (m_stat >> 6) & 1, req, "alarm_level");
    check(int'(bus_rdata), model_read(ad), req, "bus_rdata");
  endtask

  task automatic idle_read(input int ad, input string req);
    step(1'b0, 1'b0, 1'b0, ad, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state over every register
    for (int a = 0; a < 5; a++) idle_read(a, "R1");

    // R10: control write and readback, unused addresses read 0
    step(1'b0, 1'b0, 1'b1, 0, 8'h05, "R10");
    idle_read(0, "R10");
    for (int a = 5; a < 8; a++) idle_read(a, "R10");
    step(1'b0, 1'b0, 1'b1, 0, 8'h04, "R10");

    // R3 and R7: spaced ticks in mode 0 give isolated one-cycle pulses
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 1'b0, 1, 0, "R3");
      idle_read(1, "R7");
      idle_read(2, "R7");
    end

    // R8: writing zeros changes nothing, ones clear, set beats clear
    step(1'b0, 1'b0, 1'b1, 1, 8'h00, "R8");
    idle_read(1, "R8");
    step(1'b0, 1'b0, 1'b1, 1, 8'h04, "R8");
    idle_read(1, "R8");
    step(1'b1, 1'b0, 1'b1, 1, 8'h04, "R8");
    idle_read(1, "R8");

    // R7: enable off, status and counters still move, no pulse
    step(1'b0, 1'b0, 1'b1, 0, 8'h00, "R7");
    step(1'b0, 1'b0, 1'b1, 1, 8'hFF, "R7");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1, 0, "R7");
    idle_read(2, "R7");

    // R4 and R2: per-minute mode through a seconds wrap
    step(1'b0, 1'b0, 1'b1, 0, 8'h05, "R4");
    for (int i = 0; i < 130; i++) step((i % 3) != 2, 1'b0, 1'b0, (i % 2) ? 1 : 2, 0, "R4");

    // R5 and R2: per-hour mode through a minutes wrap
    step(1'b0, 1'b0, 1'b1, 0, 8'h06, "R5");
    for (int i = 0; i < 3700; i++) step(1'b1, 1'b0, 1'b0, (i % 2) ? 1 : 3, 0, "R5");

    // R6 and R2: per-day mode through an hours wrap
    step(1'b0, 1'b0, 1'b1, 0, 8'h07, "R6");
    for (int i = 0; i < 86460; i++) step(1'b1, 1'b0, 1'b0, (i % 2) ? 1 : 4, 0, "R6");

    // R9: alarm level holds until cleared
    step(1'b0, 1'b1, 1'b0, 1, 0, "R9");
    for (int i = 0; i < 4; i++) idle_read(1, "R9");
    step(1'b0, 1'b0, 1'b1, 1, 8'h3C, "R9");
    idle_read(1, "R9");
    step(1'b0, 1'b0, 1'b1, 1, 8'h40, "R9");
    idle_read(1, "R9");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule